// File: doc/BRIEF.md
# Widening SIMD Lane Subtract Unit

This block is a packed-vector integer datapath for a SIMD execution pipe. It takes two 128-bit source vectors and builds a 128-bit result whose lanes are twice as wide as the source lanes. A half-select input picks either the low or the high 64 bits of both sources. The picked 64-bit slices are cut into narrow unsigned lanes of 8, 16 or 32 bits. Each lane is zero-extended to double width, and the block then either subtracts the second source lane from the first or adds the two. Each result keeps only the doubled lane width, so a negative difference wraps.

An operation is launched by a one-cycle valid strobe. The result appears on a registered output one cycle later, together with a one-cycle valid pulse. An unsupported size code produces an illegal pulse in place of a result. A separate combinational decoder reports whether a 32-bit instruction word carries the fixed opcode pattern of this operation. The decoder can be removed by parameter. The block produces no condition flags.

Top module: `wsub_unit`

## Requirements
- R1: `size_code` 00 selects 8-bit source lanes, 01 selects 16-bit lanes and 10 selects 32-bit lanes. Result lane i, with source width e, occupies `out_data[2e*i +: 2e]`.
- R2: Both operands are unsigned and zero-extended before the operation. Adding 0xFF to 0xFF in an 8-bit lane gives 0x01FE.
- R3: Subtraction keeps the low 2e bits of the difference, so the result wraps. In an 8-bit lane, 0 minus 0xFF gives 0xFF01. In a 32-bit lane, 0xFFFFFFFF minus 0 gives 0x00000000FFFFFFFF.
- R4: With `upper_half`=0 the lanes come from bits 63:0 of both sources. With `upper_half`=1 they come from bits 127:64.
- R5: `do_add`=0 gives the first source minus the second (`src_a` − `src_b`). `do_add`=1 gives their sum.
- R6: There are 8, 4 or 2 lanes (64/e), and together they fill all 128 result bits.
- R7: When `in_valid` is high with a legal size code, `out_data` takes the result at the next rising edge and `out_valid` is high for exactly that one cycle.
- R8: When `in_valid` is high with size code 11, `illegal` pulses high for one cycle at the next edge, `out_valid` stays low and `out_data` keeps its previous value.
- R9: A synchronous active-high `rst` clears `out_data`, `out_valid` and `illegal`.
- R10: `insn_match` is high exactly when bit31=0, bit29=1, bits28:24=01110, bit21=1 and bits15:10=001000. All other bits are ignored, including the half bit 30, the size bits 23:22 and the register fields 20:16, 9:5 and 4:0.
- R11: While `in_valid` is low, `out_data` holds its value and `out_valid` and `illegal` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Launches one operation |
| upper_half | input | 1 | 0: low 64 bits, 1: high 64 bits of the sources |
| size_code | input | 2 | Source lane width code |
| do_add | input | 1 | 1: add, 0: subtract |
| src_a | input | 128 | First source vector (minuend) |
| src_b | input | 128 | Second source vector (subtrahend) |
| insn_word | input | 32 | Instruction word for the opcode check |
| out_valid | output | 1 | One-cycle result pulse |
| out_data | output | 128 | Registered widened result |
| illegal | output | 1 | One-cycle pulse for size code 11 |
| insn_match | output | 1 | Instruction word matches the opcode pattern |

## Verification
Fixed all-zero and all-ones operands are run in every lane width. Zero minus maximum and maximum minus zero show whether the borrow wraps into the doubled width and whether zero-extension is applied. Maximum plus maximum shows whether the carry lands in the upper half of each lane. Random operands are run across all sizes, both halves and both operations, with different data in the two source halves, so a wrong half pick or lane stride gives a wrong result. Instruction words with only their don't-care fields changed, and words with a single pattern bit flipped, separate the decoder's mask from its match value.

// File: rtl/wsub_pkg.sv
package wsub_pkg;

    localparam int VEC_W = 128;
    localparam int HALF_W = VEC_W / 2;

    typedef enum logic [1:0] {
        LSZ_8   = 2'b00,
        LSZ_16  = 2'b01,
        LSZ_32  = 2'b10,
        LSZ_BAD = 2'b11
    } lane_sz_e;

    typedef struct packed {
        logic     upper;
        lane_sz_e sz;
        logic     add;
    } op_ctl_t;

    typedef struct packed {
        logic             valid;
        logic             bad;
        logic [VEC_W-1:0] data;
    } op_out_t;

    localparam logic [31:0] OPC_MASK  = 32'hBF20_FC00;
    localparam logic [31:0] OPC_VALUE = 32'h2E20_2000;

    function automatic logic size_ok(lane_sz_e s);
        return s != LSZ_BAD;
    endfunction

endpackage

// File: rtl/wsub_half_pick.sv
module wsub_half_pick #(
    parameter int VW = 128
) (
    input  logic [VW-1:0]   a_in,
    input  logic [VW-1:0]   b_in,
    input  logic            upper,
    output logic [VW/2-1:0] a_half,
    output logic [VW/2-1:0] b_half
);
    localparam int HW = VW / 2;

    assign a_half = upper ? a_in[VW-1:HW] : a_in[HW-1:0];
    assign b_half = upper ? b_in[VW-1:HW] : b_in[HW-1:0];
endmodule

// File: rtl/wsub_lane_alu.sv
module wsub_lane_alu #(
    parameter int HW    = 64,
    parameter int ESIZE = 8
) (
    input  logic [HW-1:0]   a_half,
    input  logic [HW-1:0]   b_half,
    input  logic            do_add,
    output logic [2*HW-1:0] wide
);
    localparam int LANES = HW / ESIZE;
    localparam int RW    = 2 * ESIZE;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [RW-1:0] xa, xb;
        assign xa = {{ESIZE{1'b0}}, a_half[i*ESIZE +: ESIZE]};
        assign xb = {{ESIZE{1'b0}}, b_half[i*ESIZE +: ESIZE]};
        assign wide[i*RW +: RW] = do_add ? (xa + xb) : (xa - xb);
    end
endmodule

// File: rtl/wsub_opcode_match.sv
module wsub_opcode_match #(
    parameter bit ENABLE = 1'b1
) (
    input  logic [31:0] word,
    output logic        hit
);
    import wsub_pkg::*;

    if (ENABLE) begin : g_on
        assign hit = (word & OPC_MASK) == OPC_VALUE;
    end else begin : g_off
        logic unused_w;
        assign unused_w = ^word;
        assign hit = 1'b0;
    end
endmodule

// File: rtl/wsub_unit.sv
module wsub_unit
    import wsub_pkg::*;
#(
    parameter bit CHECK_OPCODE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             upper_half,
    input  logic [1:0]       size_code,
    input  logic             do_add,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [31:0]      insn_word,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data,
    output logic             illegal,
    output logic             insn_match
);
    localparam int NSZ = 3;

    op_ctl_t          ctl;
    op_out_t          q;
    logic [HALF_W-1:0] a_h, b_h;
    logic [VEC_W-1:0]  res [NSZ];
    logic [VEC_W-1:0]  res_sel;

    assign ctl = '{upper: upper_half, sz: lane_sz_e'(size_code), add: do_add};

    wsub_half_pick #(.VW(VEC_W)) u_pick (
        .a_in   (src_a),
        .b_in   (src_b),
        .upper  (ctl.upper),
        .a_half (a_h),
        .b_half (b_h)
    );

    for (genvar g = 0; g < NSZ; g++) begin : g_size
        wsub_lane_alu #(.HW(HALF_W), .ESIZE(8 << g)) u_alu (
            .a_half (a_h),
            .b_half (b_h),
            .do_add (ctl.add),
            .wide   (res[g])
        );
    end

    always_comb begin
        case (ctl.sz)
            LSZ_8:   res_sel = res[0];
            LSZ_16:  res_sel = res[1];
            default: res_sel = res[2];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= in_valid && size_ok(ctl.sz);
            q.bad   <= in_valid && !size_ok(ctl.sz);
            if (in_valid && size_ok(ctl.sz)) begin
                q.data <= res_sel;
            end
        end
    end

    assign out_valid = q.valid;
    assign illegal   = q.bad;
    assign out_data  = q.data;

    wsub_opcode_match #(.ENABLE(CHECK_OPCODE)) u_dec (
        .word (insn_word),
        .hit  (insn_match)
    );
endmodule

// File: rtl/wsub_unit_chk.sv
module wsub_unit_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         upper_half,
    input logic [1:0]   size_code,
    input logic         do_add,
    input logic [127:0] src_a,
    input logic [127:0] src_b,
    input logic [31:0]  insn_word,
    input logic         out_valid,
    input logic [127:0] out_data,
    input logic         illegal,
    input logic         insn_match
);
    a_r7_result_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_code != 2'b11) |=> (out_valid && !illegal));

    a_r8_bad_size_holds: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_code == 2'b11) |=> (illegal && !out_valid && $stable(out_data)));

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !illegal && out_data == '0));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !illegal && $stable(out_data)));

    a_r4_low_half_minus_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_code == 2'b10 && !do_add && !upper_half && src_b == '0)
        |=> out_data == {32'b0, $past(src_a[63:32]), 32'b0, $past(src_a[31:0])});

    a_r10_base_pattern: assert property (@(posedge clk)
        (insn_word == 32'h2E20_2000) |-> insn_match);
endmodule

bind wsub_unit wsub_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .upper_half (upper_half),
    .size_code  (size_code),
    .do_add     (do_add),
    .src_a      (src_a),
    .src_b      (src_b),
    .insn_word  (insn_word),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .illegal    (illegal),
    .insn_match (insn_match)
);

// File: tb/wsub_unit_test.sv
`timescale 1ns/1ps
module wsub_unit_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         upper_half = 1'b0;
    logic [1:0]   size_code = 2'b00;
    logic         do_add = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [31:0]  insn_word = '0;
    logic         out_valid;
    logic [127:0] out_data;
    logic         illegal;
    logic         insn_match;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    int cycles = 0;

    // Reference model state
    logic         m_valid = 1'b0;
    logic         m_bad = 1'b0;
    logic [127:0] m_data = '0;

    always #10 clk = ~clk;

    wsub_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .upper_half(upper_half),
        .size_code(size_code), .do_add(do_add), .src_a(src_a), .src_b(src_b),
        .insn_word(insn_word), .out_valid(out_valid), .out_data(out_data),
        .illegal(illegal), .insn_match(insn_match)
    );

    function automatic logic [127:0] ref_calc(logic [127:0] a, logic [127:0] b,
                                              logic up, logic [1:0] sz, logic add);
        logic [63:0]  ha, hb, m1, m2, x, y, r;
        logic [127:0] acc;
        int es, n;
        es = 8 << sz;
        n  = 64 / es;
        ha = up ? a[127:64] : a[63:0];
        hb = up ? b[127:64] : b[63:0];
        m1 = (64'd1 << es) - 64'd1;
        m2 = (es == 32) ? '1 : ((64'd1 << (2 * es)) - 64'd1);
        acc = '0;
        for (int i = 0; i < n; i++) begin
            x = (ha >> (i * es)) & m1;
            y = (hb >> (i * es)) & m1;
            r = add ? (x + y) : (x - y);
            r = r & m2;
            acc = acc | ({64'b0, r} << (i * 2 * es));
        end
        return acc;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle model update
    always @(posedge clk) begin
        if (rst) begin
            m_valid <= 1'b0;
            m_bad   <= 1'b0;
            m_data  <= '0;
        end else begin
            m_valid <= in_valid && size_code != 2'b11;
            m_bad   <= in_valid && size_code == 2'b11;
            if (in_valid && size_code != 2'b11)
                m_data <= ref_calc(src_a, src_b, upper_half, size_code, do_add);
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (running) begin
            check(out_valid === m_valid, "R7 out_valid", {127'b0, out_valid}, {127'b0, m_valid});
            check(illegal === m_bad, "R8 illegal", {127'b0, illegal}, {127'b0, m_bad});
            check(out_data === m_data, "R1/R11 out_data", out_data, m_data);
        end
    end

    task automatic launch(input logic [127:0] a, input logic [127:0] b, input logic up,
                          input logic [1:0] sz, input logic add);
        src_a = a; src_b = b; upper_half = up; size_code = sz; do_add = add;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic directed(input logic [127:0] a, input logic [127:0] b, input logic up,
                            input logic [1:0] sz, input logic add,
                            input logic [127:0] exp, input string tag);
        launch(a, b, up, sz, add);
        check(out_valid === 1'b1, tag, {127'b0, out_valid}, 128'd1);
        check(out_data === exp, tag, out_data, exp);
    endtask

    task automatic dec_check(input logic [31:0] w, input bit exp);
        insn_word = w;
        #1;
        check(insn_match === exp, "R10 opcode match", {127'b0, insn_match}, {127'b0, exp});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL R7 watchdog: actual hung expected finished");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid === 1'b0 && illegal === 1'b0 && out_data === '0, "R9 reset state",
              out_data, '0);
        rst = 1'b0;
        running = 1'b1;
        @(negedge clk);

        // R3: zero minus maximum, 8-bit lanes
        directed('0, '1, 1'b0, 2'b00, 1'b0, {8{16'hFF01}}, "R3 8b 0-max");
        // R2: carry from zero-extension, 8-bit lanes
        directed('1, '1, 1'b0, 2'b00, 1'b1, {8{16'h01FE}}, "R2 8b max+max");
        // R3: 16-bit lanes 0 - max
        directed('0, '1, 1'b1, 2'b01, 1'b0, {4{32'hFFFF_0001}}, "R3 16b 0-max");
        // R3/R4: 32-bit max - 0 from the upper half only
        directed({64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, '0, 1'b1, 2'b10, 1'b0,
                 {2{64'h0000_0000_FFFF_FFFF}}, "R4 upper 32b max-0");
        directed('0, '1, 1'b0, 2'b10, 1'b0, {2{64'hFFFF_FFFF_0000_0001}}, "R3 32b 0-max");
        // R4: lower half chosen, upper half data ignored
        directed({64'hDEAD_BEEF_0123_4567, 64'h0000_0005_0000_0009},
                 {64'h1111_1111_1111_1111, 64'h0000_0002_0000_0003}, 1'b0, 2'b10, 1'b0,
                 {64'd3, 64'd6}, "R4 lower half");
        // R5/R6: add with 16-bit lanes, every lane distinct
        directed({64'h0, 64'h0004_0003_0002_0001}, {64'h0, 64'h0040_0030_0020_0010},
                 1'b0, 2'b01, 1'b1,
                 {32'h44, 32'h33, 32'h22, 32'h11}, "R5 R6 16b add lanes");

        // R8: illegal size keeps data
        held = out_data;
        launch('1, '0, 1'b0, 2'b11, 1'b0);
        check(illegal === 1'b1 && out_valid === 1'b0, "R8 illegal pulse",
              {126'b0, illegal, out_valid}, 128'd2);
        check(out_data === held, "R8 data held", out_data, held);

        // R11: idle cycles hold data
        repeat (3) @(negedge clk);
        check(out_data === held && out_valid === 1'b0, "R11 idle hold", out_data, held);

        // R1/R4/R5/R6: random sweep against model (compared every clock)
        for (int k = 0; k < 300; k++) begin
            logic [127:0] ra, rb;
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            if (k % 7 == 0) ra = '0;
            if (k % 11 == 0) rb = '1;
            launch(ra, rb, k[0], 2'(k % 4), k[1]);
            if (k % 5 == 0) @(negedge clk);
        end

        // R10: instruction decode
        dec_check(32'h2E20_2000, 1'b1);
        dec_check(32'h6EA0_2000, 1'b1);
        dec_check(32'h2E3F_23FF, 1'b1);
        dec_check(32'h2EE0_2000, 1'b1);
        dec_check(32'hAE20_2000, 1'b0);
        dec_check(32'h0E20_2000, 1'b0);
        dec_check(32'h2E00_2000, 1'b0);
        dec_check(32'h2E20_2400, 1'b0);
        dec_check(32'h2F20_2000, 1'b0);

        // R9: mid-run reset
        launch('1, '0, 1'b0, 2'b00, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0 && out_data === '0, "R9 mid-run reset", out_data, '0);
        rst = 1'b0;
        @(negedge clk);

        running = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule